// File: doc/BRIEF.md
# Hierarchical Zero-Suppression Readout Sequencer

This block reads out a pixel matrix that is split into double columns. Each double column is a stack of superpixels, and each superpixel is 2 pixels wide and 8 rows tall. Every pixel has a hit flag and a data word. A one-cycle `start` strobe latches all hit flags in a single edge. From then on the latched flags steer the sequencer, so the acquisition side may change its flag lines at once.

The sequencer sends one bit per clock on `ser_bit`, qualified by `ser_valid`. For each column it first sends one bit that says whether the column holds any hit. For a column that has a hit, it sends one bit per superpixel. For a superpixel that has a hit, it sends one bit per pixel. For a pixel that has a hit, the pixel's data word follows its flag bit. An empty column therefore costs one bit, and an empty superpixel inside an occupied column also costs one bit. Only the column under readout has its clock enable raised. A one-cycle `done` pulse closes the frame.

Top module: `zs_col_readout`

## Requirements
- R1: After reset `ser_valid`, `done` and every bit of `col_en` are 0, and they stay 0 until `start` is sampled high.
- R2: A high `start` sampled while no frame is in progress copies `hit_flags` into an internal register. The first stream bit appears in the next cycle. Later changes on `hit_flags` do not alter that frame.
- R3: Columns are visited in ascending order, column 0 first. Each column sends one bit, which is the OR of the latched flags of all its pixels. A 0 bit ends that column with nothing further sent for it.
- R4: Inside a column whose bit is 1, each superpixel sends one bit, which is the OR of its 16 latched flags. Superpixel 0, which holds the lowest pixel indexes, goes first. A 0 bit skips the whole superpixel.
- R5: Inside a superpixel whose bit is 1, each of its 16 pixels sends its latched flag in row-major order: row 0 left, row 0 right, row 1 left, and so on. The flat pixel index is col*16*SP_PER_COL + sp*16 + row*2 + side.
- R6: A pixel whose flag bit is 1 is followed at once by its DW-bit word from `pix_data[index*DW +: DW]`, most significant bit first. A pixel with a 0 flag sends no data bits.
- R7: `ser_valid` is high in one unbroken run whose length is NCOLS + SP_PER_COL × (occupied columns) + 16 × (occupied superpixels) + DW × (hit pixels).
- R8: `done` is high for exactly one cycle, the cycle right after the last stream bit.
- R9: While a frame is in progress `col_en` is one-hot and marks the column whose bits are being sent. While idle it is all zero.
- R10: A `start` pulse during a frame in progress is ignored. The stream continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Readout request strobe |
| hit_flags | input | NCOLS*SP_PER_COL*16 | Per-pixel hit flags |
| pix_data | input | NCOLS*SP_PER_COL*16*DW | Per-pixel data words, pixel i at [i*DW +: DW] |
| ser_bit | output | 1 | Serial stream bit |
| ser_valid | output | 1 | Stream bit qualifier |
| done | output | 1 | End-of-frame pulse |
| col_en | output | NCOLS | Clock enable of the column being read |

## Verification
The bench drives `start` at a falling edge, and the rising edge that follows latches the flags. A reference queue of expected bits is built from the flags present at that edge, and its first entry must appear at the very next falling edge. From then on the bench pops one entry per clock and compares `ser_bit`, `ser_valid` and `col_en` at each falling edge. At the first falling edge after the queue empties, `done` must be high. At the falling edge after that, `done` and `ser_valid` must both be low. A disturbance frame flips the flags and pulses `start` during the stream to show that the frame is unaffected.

// File: rtl/zs_col_readout.sv
module zs_col_readout #(
  parameter int NCOLS      = 4,
  parameter int SP_PER_COL = 2,
  parameter int DW         = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  start,
  input  logic [NCOLS*SP_PER_COL*16-1:0]        hit_flags,
  input  logic [NCOLS*SP_PER_COL*16*DW-1:0]     pix_data,
  output logic                                  ser_bit,
  output logic                                  ser_valid,
  output logic                                  done,
  output logic [NCOLS-1:0]                      col_en
);
  localparam int NSP  = NCOLS * SP_PER_COL;
  localparam int NPIX = NSP * 16;
  localparam int CW   = (NCOLS > 1) ? $clog2(NCOLS) : 1;
  localparam int SW   = (SP_PER_COL > 1) ? $clog2(SP_PER_COL) : 1;
  localparam int SIW  = (NSP > 1) ? $clog2(NSP) : 1;
  localparam int BW   = (DW > 1) ? $clog2(DW) : 1;

  typedef enum logic [2:0] {IDLE, COLF, SPF, PXF, DATA} st_t;

  st_t              st;
  logic [NPIX-1:0]  flg;
  logic [NSP-1:0]   spf;
  logic [NCOLS-1:0] colf;
  logic [CW-1:0]    col;
  logic [SW-1:0]    sp;
  logic [3:0]       px;
  logic [BW-1:0]    bc;
  logic [SIW-1:0]   spi;
  logic [SIW+3:0]   pidx;
  logic [DW-1:0]    word;
  logic             fin_px, fin_sp, fin_col, fin_all;

  for (genvar g = 0; g < NSP; g++) begin : g_sp
    assign spf[g] = |flg[g*16 +: 16];
  end
  for (genvar c = 0; c < NCOLS; c++) begin : g_col
    assign colf[c]   = |spf[c*SP_PER_COL +: SP_PER_COL];
    assign col_en[c] = (st != IDLE) && (col == CW'(c));
  end

  assign spi  = SIW'(col) * SIW'(SP_PER_COL) + SIW'(sp);
  assign pidx = {spi, px};
  assign word = pix_data[int'(pidx)*DW +: DW];

  assign fin_px  = (st == PXF && !flg[pidx]) || (st == DATA && bc == '0);
  assign fin_sp  = (st == SPF && !spf[spi]) || (fin_px && px == 4'd15);
  assign fin_col = (st == COLF && !colf[col]) || (fin_sp && sp == SW'(SP_PER_COL-1));
  assign fin_all = fin_col && col == CW'(NCOLS-1);

  always_comb begin
    case (st)
      COLF:    ser_bit = colf[col];
      SPF:     ser_bit = spf[spi];
      PXF:     ser_bit = flg[pidx];
      DATA:    ser_bit = word[bc];
      default: ser_bit = 1'b0;
    endcase
  end
  assign ser_valid = (st != IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= IDLE;
      flg  <= '0;
      col  <= '0;
      sp   <= '0;
      px   <= '0;
      bc   <= '0;
      done <= 1'b0;
    end else begin
      done <= fin_all;
      if (st == IDLE) begin
        if (start) begin
          flg <= hit_flags;
          col <= '0;
          st  <= COLF;
        end
      end else if (fin_all) begin
        st <= IDLE;
      end else if (fin_col) begin
        col <= col + 1'b1;
        st  <= COLF;
      end else if (fin_sp) begin
        sp <= sp + 1'b1;
        st <= SPF;
      end else if (fin_px) begin
        px <= px + 1'b1;
        st <= PXF;
      end else begin
        case (st)
          COLF: begin sp <= '0; st <= SPF; end
          SPF:  begin px <= '0; st <= PXF; end
          PXF:  begin bc <= BW'(DW-1); st <= DATA; end
          DATA: bc <= bc - 1'b1;
          default: st <= IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/zs_col_readout_chk.sv
module zs_col_readout_chk #(
  parameter int NCOLS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             ser_valid,
  input logic             done,
  input logic [NCOLS-1:0] col_en
);
  assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !ser_valid |=> ser_valid);
  assert_stream_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_valid) |-> $past(start));
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_stream_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ser_valid && $past(ser_valid));
  assert_col_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(col_en));
  assert_idle_no_col_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_valid |-> col_en == '0);
  assert_busy_col_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid |-> $countones(col_en) == 1);
endmodule

bind zs_col_readout zs_col_readout_chk #(.NCOLS(NCOLS)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start),
  .ser_valid(ser_valid), .done(done), .col_en(col_en)
);

// File: tb/zs_col_readout_tb_top.sv
module zs_col_readout_tb_top;
  localparam int NCOLS = 4;
  localparam int SPC   = 2;
  localparam int DW    = 8;
  localparam int NPIX  = NCOLS * SPC * 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NPIX-1:0]    hit_flags = '0;
  logic [NPIX*DW-1:0] pix_data = '0;
  logic ser_bit, ser_valid, done;
  logic [NCOLS-1:0] col_en;

  int tests = 0;
  int fails = 0;
  int q[$];

  always #5 clk = ~clk;

  zs_col_readout #(.NCOLS(NCOLS), .SP_PER_COL(SPC), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .hit_flags(hit_flags),
    .pix_data(pix_data), .ser_bit(ser_bit), .ser_valid(ser_valid),
    .done(done), .col_en(col_en)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected stream entries are col*2+bit. Column bits cover R3, superpixel bits R4,
  // pixel flags R5 and data words R6.
  function automatic int build(input logic [NPIX-1:0] f, input logic [NPIX*DW-1:0] d);
    int len = 0;
    q.delete();
    for (int c = 0; c < NCOLS; c++) begin
      bit cf = 0;
      for (int p = 0; p < SPC*16; p++) cf |= f[c*SPC*16+p];
      q.push_back(c*2 + int'(cf)); len++;
      if (cf) begin
        len += SPC;
        for (int s = 0; s < SPC; s++) begin
          bit sf = 0;
          for (int p = 0; p < 16; p++) sf |= f[(c*SPC+s)*16+p];
          q.push_back(c*2 + int'(sf));
          if (sf) begin
            len += 16;
            for (int p = 0; p < 16; p++) begin
              int idx = (c*SPC+s)*16 + p;
              q.push_back(c*2 + int'(f[idx]));
              if (f[idx]) begin
                len += DW;
                for (int b = DW-1; b >= 0; b--) q.push_back(c*2 + int'(d[idx*DW+b]));
              end
            end
          end
        end
      end
    end
    return len;
  endfunction

  task automatic run_frame(input logic [NPIX-1:0] f, input bit disturb, input string tag);
    int len, cnt, e;
    @(negedge clk);
    hit_flags = f;
    start = 1'b1;
    len = build(f, pix_data);
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (q.size() > 0) begin
      e = q.pop_front();
      check(ser_valid === 1'b1, "R7 valid during stream", int'(ser_valid), 1);
      check(ser_bit === e[0], "R3/R4/R5/R6 stream bit", int'(ser_bit), e[0]);
      check(col_en === NCOLS'(1 << (e >> 1)), "R9 column enable", int'(col_en), 1 << (e >> 1));
      cnt++;
      if (disturb && cnt == 1) begin hit_flags = ~f; end
      if (disturb && cnt == 3) begin start = 1'b1; end
      if (disturb && cnt == 4) begin start = 1'b0; end
      @(negedge clk);
    end
    check(done === 1'b1, "R8 done after last bit", int'(done), 1);
    check(ser_valid === 1'b0, "R7 stream ends", int'(ser_valid), 0);
    check(col_en === '0, "R9 idle enable", int'(col_en), 0);
    check(cnt == len, {"R7 length ", tag}, cnt, len);
    @(negedge clk);
    check(done === 1'b0, "R8 done single cycle", int'(done), 0);
    check(ser_valid === 1'b0, "R10 no restart", int'(ser_valid), 0);
  endtask

  initial begin
    logic [NPIX-1:0] f;
    for (int i = 0; i < NPIX*DW/32; i++) pix_data[i*32 +: 32] = $urandom();
    repeat (3) @(negedge clk);
    check(ser_valid === 1'b0 && done === 1'b0 && col_en === '0, "R1 reset state", int'(ser_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(ser_valid === 1'b0 && done === 1'b0 && col_en === '0, "R1 idle after reset", int'(ser_valid), 0);
    run_frame('0, 1'b0, "empty");
    run_frame('1, 1'b0, "full");
    f = '0; f[0] = 1'b1;
    run_frame(f, 1'b0, "first pixel");
    f = '0; f[NPIX-1] = 1'b1;
    run_frame(f, 1'b0, "last pixel");
    f = '0; f[SPC*16 + 17] = 1'b1; f[3*SPC*16 + 2] = 1'b1;
    run_frame(f, 1'b0, "two columns");
    for (int k = 0; k < 6; k++) begin
      for (int p = 0; p < NPIX; p++) f[p] = ($urandom() % 16) == 0;
      run_frame(f, 1'b0, "random sparse");
    end
    for (int p = 0; p < NPIX; p++) f[p] = ($urandom() % 8) == 0;
    run_frame(f, 1'b1, "R2/R10 disturb");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule